// File: doc/BRIEF.md
# Proximity Threshold Event Detector

This block decides whether an object is near a capacitive sensing electrode. Its input is a stream of signed difference samples, one per conversion. A channel tag marks each sample as coming from the measurement phase or the reference phase. Only measurement samples can change the decision. The block holds a single near/far state and compares every measurement sample against two levels:

- The detect level is the threshold plus a hysteresis margin.
- The release level is the threshold minus that margin.

The threshold comes from an 8-bit code through a square law. The margin is a right shift of that threshold.

Entry into the near state and return to the far state each have their own debounce field. A transition therefore happens only after a run of qualifying samples whose length is a power of two. Each transition sets a sticky interrupt-source flag, and the flag stays set until the host writes a one to the matching clear bit. The host programs the threshold code and a configuration byte, reads the near/far status bit, and services the interrupt flags.

Top module: `prox_event_det`

## Requirements
- R1: After reset the state is far (`near_stat` = 0), both debounce counts are empty and `irq_src` is 0.
- R2: The effective threshold T equals the code when the code is 0 or 1. For any other code it equals floor(code*code/2). For example, code 8 gives T = 32 and code 255 gives T = 32512.
- R3: The hysteresis field is `cfg_byte[5:4]` = h. When h = 0 the margin H is 0. Otherwise H = T >> (5 - h), so h = 1, 2 and 3 shift T right by 4, 3 and 2 bits respectively.
- R4: In the far state, a measurement sample qualifies for entry when it is greater than or equal to T + H (signed compare).
- R5: In the near state, a measurement sample qualifies for release when it is strictly less than T - H (signed compare).
- R6: The entry debounce field is `cfg_byte[3:2]` = n. A nonzero n requires 2^n consecutive qualifying measurement samples before entry. When n = 0 a single qualifying sample is enough.
- R7: The release debounce field is `cfg_byte[1:0]` and works the same way as R6, independently of the entry field.
- R8: A measurement sample that does not qualify empties the count of the pending transition.
- R9: Entry to the near state sets `irq_src[3]`, and return to the far state sets `irq_src[2]`. Both flags stay set until the host writes a one to the same bit position of `irq_clr`. A flag being set wins over a clear in the same cycle. All other bits of `irq_src` read 0.
- R10: A cycle with `smp_vld` = 0, or a sample with `smp_chan` = 0 (reference phase), changes neither the state nor any flag.
- R11: Only `smp_data[11:0]` is used, as a two's-complement value. Bits [15:12] of the container are ignored.
- R12: The state and the flags update at the clock edge that captures the deciding sample, and are visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per conversion |
| smp_chan | input | 1 | Phase tag: 1 = measurement, 0 = reference |
| smp_data | input | 16 | Sample container; bits [11:0] hold the signed value |
| thr_code | input | 8 | Square-law threshold code |
| cfg_byte | input | 8 | [5:4] hysteresis select, [3:2] entry debounce, [1:0] release debounce |
| irq_clr | input | 8 | Write-one-to-clear strobe for the interrupt flags |
| near_stat | output | 1 | 1 = object near, 0 = far |
| irq_src | output | 8 | Interrupt sources: bit 3 near entry, bit 2 far return |

## Verification
Every result is due one edge after the edge that captures the deciding sample or the clear strobe. No intermediate register sits between the comparison and the state or flag registers. The bench therefore drives each sample on a falling edge, lets one rising edge capture it, and samples the outputs on the following falling edge. Debounce runs are checked after every sample, so a transition that arrives one sample early or late is caught. Cases where the input has no effect are checked in the same way, on the falling edge after the ignored stimulus.

// File: rtl/prox_pkg.sv
package prox_pkg;
   localparam int SMP_W       = 12;
   localparam int CONT_W      = 16;
   localparam int CODE_W      = 8;
   localparam int CFG_W       = 8;
   localparam int FLD_W       = 2;
   localparam int IRQ_W       = 8;
   localparam int IRQ_NEAR    = 3;
   localparam int IRQ_FAR     = 2;
   localparam int HYS_LSB     = 4;
   localparam int ENT_LSB     = 2;
   localparam int REL_LSB     = 0;

   typedef enum logic {ST_FAR = 1'b0, ST_NEAR = 1'b1} prox_state_e;
endpackage

// File: rtl/prox_thr_calc.sv
module prox_thr_calc #(
   parameter int CODE_W = 8,
   parameter int FLD_W  = 2,
   localparam int THR_W = 2*CODE_W - 1
) (
   input  logic [CODE_W-1:0] code,
   input  logic [FLD_W-1:0]  hsel,
   output logic [THR_W:0]    lvl_hi,
   output logic [THR_W:0]    lvl_lo
);
   localparam int SHIFT_BASE = (1 << FLD_W) + 1;

   logic [2*CODE_W-1:0] sq;
   logic [THR_W-1:0]    thr;
   logic [THR_W-1:0]    hyst;

   always_comb begin
      sq = code * code;
      if (code <= CODE_W'(1))
         thr = THR_W'(code);
      else
         thr = sq[2*CODE_W-1:1];
      if (hsel == '0)
         hyst = '0;
      else
         hyst = thr >> (SHIFT_BASE - int'(hsel));
      lvl_hi = {1'b0, thr} + {1'b0, hyst};
      lvl_lo = {1'b0, thr} - {1'b0, hyst};
   end
endmodule

// File: rtl/prox_debounce.sv
module prox_debounce #(
   parameter int FLD_W = 2,
   localparam int CNT_W = (1 << FLD_W) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             step,
   input  logic             qual,
   input  logic [FLD_W-1:0] len_sel,
   output logic             fire
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] need;
   logic [CNT_W-1:0] cnt_inc;

   always_comb begin
      need    = CNT_W'(1) << len_sel;
      cnt_inc = cnt + CNT_W'(1);
      fire    = arm && step && qual && (cnt_inc >= need);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !arm)
         cnt <= '0;
      else if (step) begin
         if (!qual || fire)
            cnt <= '0;
         else
            cnt <= cnt_inc;
      end
   end
endmodule

// File: rtl/prox_event_det.sv
module prox_event_det
   import prox_pkg::*;
#(
   parameter int P_SMP_W  = SMP_W,
   parameter int P_CONT_W = CONT_W,
   parameter int P_CODE_W = CODE_W,
   parameter int P_IRQ_W  = IRQ_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld,
   input  logic                smp_chan,
   input  logic [P_CONT_W-1:0] smp_data,
   input  logic [P_CODE_W-1:0] thr_code,
   input  logic [CFG_W-1:0]    cfg_byte,
   input  logic [P_IRQ_W-1:0]  irq_clr,
   output logic                near_stat,
   output logic [P_IRQ_W-1:0]  irq_src
);
   localparam int THR_W = 2*P_CODE_W - 1;
   localparam int CMP_W = THR_W + 2;

   if (P_SMP_W > P_CONT_W) begin : g_bad_width
      $error("sample wider than its container");
   end
   if (P_IRQ_W <= IRQ_NEAR) begin : g_bad_irq
      $error("interrupt vector too narrow");
   end
   if (CMP_W <= P_SMP_W) begin : g_bad_cmp
      $error("threshold range narrower than sample");
   end

   prox_state_e         st;
   logic [THR_W:0]      lvl_hi, lvl_lo;
   logic signed [CMP_W-1:0] smp_s, hi_s, lo_s;
   logic                meas_step;
   logic [1:0]          arm, qual, fire;
   logic [1:0][FLD_W-1:0] len_sel;
   logic                flag_near, flag_far;

   prox_thr_calc #(.CODE_W(P_CODE_W), .FLD_W(FLD_W)) u_thr (
      .code   (thr_code),
      .hsel   (cfg_byte[HYS_LSB +: FLD_W]),
      .lvl_hi (lvl_hi),
      .lvl_lo (lvl_lo)
   );

   always_comb begin
      smp_s     = CMP_W'(signed'(smp_data[P_SMP_W-1:0]));
      hi_s      = signed'({1'b0, lvl_hi});
      lo_s      = signed'({1'b0, lvl_lo});
      meas_step = smp_vld && smp_chan;
      arm[0]    = (st == ST_FAR);
      arm[1]    = (st == ST_NEAR);
      qual[0]   = (smp_s >= hi_s);
      qual[1]   = (smp_s <  lo_s);
      len_sel[0] = cfg_byte[ENT_LSB +: FLD_W];
      len_sel[1] = cfg_byte[REL_LSB +: FLD_W];
   end

   for (genvar i = 0; i < 2; i++) begin : g_deb
      prox_debounce #(.FLD_W(FLD_W)) u_deb (
         .clk     (clk),
         .rst_n   (rst_n),
         .arm     (arm[i]),
         .step    (meas_step),
         .qual    (qual[i]),
         .len_sel (len_sel[i]),
         .fire    (fire[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_FAR;
         flag_near <= 1'b0;
         flag_far  <= 1'b0;
      end else begin
         if (fire[0])
            st <= ST_NEAR;
         else if (fire[1])
            st <= ST_FAR;
         flag_near <= (flag_near && !irq_clr[IRQ_NEAR]) || fire[0];
         flag_far  <= (flag_far  && !irq_clr[IRQ_FAR])  || fire[1];
      end
   end

   always_comb begin
      near_stat          = (st == ST_NEAR);
      irq_src            = '0;
      irq_src[IRQ_NEAR]  = flag_near;
      irq_src[IRQ_FAR]   = flag_far;
   end
endmodule

// File: rtl/prox_event_chk.sv
module prox_event_chk
   import prox_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             smp_vld,
   input logic             smp_chan,
   input logic [IRQ_W-1:0] irq_clr,
   input logic             near_stat,
   input logic [IRQ_W-1:0] irq_src
);
   // R10
   ignore_no_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_vld && smp_chan) |=> $stable(near_stat));

   // R9
   near_flag_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(near_stat) |-> irq_src[IRQ_NEAR]);

   // R9
   far_flag_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(near_stat) |-> irq_src[IRQ_FAR]);

   // R9
   near_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_src[IRQ_NEAR] && !irq_clr[IRQ_NEAR]) |=> irq_src[IRQ_NEAR]);

   // R9
   far_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_src[IRQ_FAR] && !irq_clr[IRQ_FAR]) |=> irq_src[IRQ_FAR]);

   // R9
   spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(irq_src) == $countones({irq_src[IRQ_NEAR], irq_src[IRQ_FAR]}));
endmodule

bind prox_event_det prox_event_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_vld   (smp_vld),
   .smp_chan  (smp_chan),
   .irq_clr   (irq_clr),
   .near_stat (near_stat),
   .irq_src   (irq_src)
);

// File: tb/sim_prox_event_det.sv
module sim_prox_event_det;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic        smp_chan = 1'b0;
   logic [15:0] smp_data = '0;
   logic [7:0]  thr_code = '0;
   logic [7:0]  cfg_byte = '0;
   logic [7:0]  irq_clr = '0;
   logic        near_stat;
   logic [7:0]  irq_src;

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] clr_with = '0;

   always #2 clk = ~clk;

   prox_event_det u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_chan(smp_chan),
      .smp_data(smp_data), .thr_code(thr_code), .cfg_byte(cfg_byte),
      .irq_clr(irq_clr), .near_stat(near_stat), .irq_src(irq_src)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; smp_vld = 1'b0; irq_clr = '0; clr_with = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input logic ch, input logic [15:0] d);
      @(negedge clk);
      smp_vld = 1'b1; smp_chan = ch; smp_data = d; irq_clr = clr_with;
      @(posedge clk);
      @(negedge clk);
      smp_vld = 1'b0; irq_clr = '0;
   endtask

   task automatic meas(input int v);
      send(1'b1, 16'(v));
   endtask

   task automatic clear(input logic [7:0] m);
      @(negedge clk);
      irq_clr = m;
      @(posedge clk);
      @(negedge clk);
      irq_clr = '0;
   endtask

   task automatic t_reset();
      thr_code = 8; cfg_byte = 0;
      do_reset();
      chk("R1 state", near_stat, 0);
      chk("R1 irq", irq_src, 0);
   endtask

   task automatic t_law();
      thr_code = 8; cfg_byte = 0; do_reset();
      meas(31); chk("R2 code8 below", near_stat, 0);
      meas(32); chk("R4 code8 at T", near_stat, 1);
      chk("R12 flag with state", irq_src, 8);
      thr_code = 255; do_reset();
      meas(2047); chk("R2 code255 unreachable", near_stat, 0);
      thr_code = 1; do_reset();
      meas(0); chk("R2 code1 below", near_stat, 0);
      meas(1); chk("R2 code1 at", near_stat, 1);
      thr_code = 0; do_reset();
      meas(0); chk("R2 code0 at zero", near_stat, 1);
      meas(-1); chk("R5 negative release", near_stat, 0);
      chk("R9 both flags", irq_src, 12);
   endtask

   task automatic t_hyst();
      thr_code = 16;
      cfg_byte = 8'h20; do_reset();
      meas(143); chk("R3 h2 below hi", near_stat, 0);
      meas(144); chk("R3 h2 at hi", near_stat, 1);
      meas(112); chk("R5 h2 at lo", near_stat, 1);
      meas(111); chk("R5 h2 below lo", near_stat, 0);
      cfg_byte = 8'h10; do_reset();
      meas(135); chk("R3 h1 below hi", near_stat, 0);
      meas(136); chk("R3 h1 at hi", near_stat, 1);
      meas(120); chk("R3 h1 at lo", near_stat, 1);
      meas(119); chk("R3 h1 below lo", near_stat, 0);
      cfg_byte = 8'h30; do_reset();
      meas(159); chk("R3 h3 below hi", near_stat, 0);
      meas(160); chk("R3 h3 at hi", near_stat, 1);
      meas(96);  chk("R3 h3 at lo", near_stat, 1);
      meas(95);  chk("R3 h3 below lo", near_stat, 0);
   endtask

   task automatic t_entry_deb();
      thr_code = 8; cfg_byte = 8'h08; do_reset();
      for (int i = 0; i < 3; i++) begin
         meas(40); chk("R6 n2 early", near_stat, 0);
      end
      meas(40); chk("R6 n2 fourth", near_stat, 1);
      do_reset();
      for (int i = 0; i < 3; i++) meas(40);
      meas(10); chk("R8 break", near_stat, 0);
      for (int i = 0; i < 3; i++) begin
         meas(40); chk("R8 restart early", near_stat, 0);
      end
      meas(40); chk("R8 restart done", near_stat, 1);
      cfg_byte = 8'h0C; do_reset();
      for (int i = 0; i < 7; i++) meas(40);
      chk("R6 n3 seventh", near_stat, 0);
      meas(40); chk("R6 n3 eighth", near_stat, 1);
   endtask

   task automatic t_release_deb();
      thr_code = 8; cfg_byte = 8'h01; do_reset();
      meas(40); chk("R7 entry undebounced", near_stat, 1);
      clear(8'h08);
      meas(10); chk("R7 first low", near_stat, 1);
      meas(40); meas(10); chk("R8 release restart", near_stat, 1);
      meas(10); chk("R7 second low", near_stat, 0);
      chk("R9 far flag only", irq_src, 4);
   endtask

   task automatic t_ignore();
      thr_code = 8; cfg_byte = 0; do_reset();
      send(1'b0, 16'd100); chk("R10 ref ignored", near_stat, 0);
      chk("R10 ref no flag", irq_src, 0);
      @(negedge clk); smp_chan = 1'b1; smp_data = 16'd100; smp_vld = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R10 no strobe", near_stat, 0);
      meas(100); chk("R10 meas works", near_stat, 1);
      send(1'b0, 16'hFF9C); chk("R10 ref low ignored", near_stat, 1);
      chk("R10 ref no far flag", irq_src, 8);
   endtask

   task automatic t_container();
      thr_code = 8; cfg_byte = 0; do_reset();
      send(1'b1, 16'h1000); chk("R11 upper bits ignored", near_stat, 0);
      send(1'b1, 16'hF020); chk("R11 low field used", near_stat, 1);
      send(1'b1, 16'h0800); chk("R11 sign bit", near_stat, 0);
   endtask

   task automatic t_irq();
      thr_code = 8; cfg_byte = 0; do_reset();
      meas(40); chk("R9 near flag", irq_src, 8);
      meas(40); chk("R9 sticky", irq_src, 8);
      clear(8'hF7); chk("R9 other clr no effect", irq_src, 8);
      clear(8'h08); chk("R9 cleared", irq_src, 0);
      chk("R9 state kept", near_stat, 1);
      clr_with = 8'h04; meas(0); clr_with = '0;
      chk("R9 set wins", irq_src, 4);
   endtask

   initial begin
      int timeout = 0;
      fork
         begin
            t_reset(); t_law(); t_hyst(); t_entry_deb();
            t_release_deb(); t_ignore(); t_container(); t_irq();
         end
         begin
            repeat (20000) @(posedge clk);
            timeout = 1;
         end
      join_any
      if (timeout) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=1 expected=0");
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule